// File: doc/BRIEF.md
# Banked Internal Data RAM with Bit Access and Stack Pointer

This block is the 128-byte on-chip data store of a small 8-bit core. A single operation code per clock selects how the storage is reached. Plain byte accesses use a 7-bit byte address. Register accesses name one of eight working registers, and the address comes from a bank register holding one of four banks. Single-bit operations reach a 16-byte window as 128 separately numbered bits. The bits in that window can be set, cleared or read.

The block also holds a 7-bit stack pointer. A push increments the pointer and then stores at the new address. A pop reads at the current address and then decrements the pointer. Software can load the pointer directly. Byte, register and pop reads return data one cycle after the request on a registered output, and bit reads do the same on a separate one-bit output. The bytes from 30H to 7FH have no special mapping and are reached only as bytes or through the stack.

Top module: `iram_banked`

## Requirements
- R1: After reset the stack pointer is 07H, the active bank is 0, and both read outputs are 0.
- R2: Operation code 2 writes wdata_i to byte byte_addr_i (00H–7FH). Operation code 1 returns that byte on rdata_o in the cycle after the request.
- R3: Operation code 11 loads the bank register from bank_sel_i. Register accesses (code 3 read, code 4 write) use register reg_num_i n in the active bank k and reach byte k*8 + n.
- R4: Bit address b selects bit b[2:0] of byte 20H + b[6:3]. For example, bit 67H is bit 7 of byte 2CH.
- R5: Operation code 6 sets the selected bit and code 7 clears it. The other seven bits of that byte keep their values.
- R6: Operation code 5 returns the selected bit on bit_rdata_o in the cycle after the request.
- R7: A push (code 8) first increments the stack pointer and then writes wdata_i at the new pointer value. The first push after reset therefore writes byte 08H.
- R8: A pop (code 9) returns the byte at the current stack pointer on rdata_o and then decrements the pointer.
- R9: Operation code 10 loads the stack pointer from wdata_i[6:0], and the next operation uses the new value. Stack addresses wrap modulo 128. Only codes 8, 9 and 10 change the pointer.
- R10: One operation is done per clock. rdata_o changes only on codes 1, 3 and 9, and bit_rdata_o changes only on code 5. Code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 4 | Operation code for this cycle |
| byte_addr_i | input | 7 | Byte address for byte operations |
| reg_num_i | input | 3 | Working register number for register operations |
| bank_sel_i | input | 2 | Bank number loaded by the bank-select operation |
| bit_addr_i | input | 7 | Bit number for bit operations |
| wdata_i | input | 8 | Write data for byte, register, push and stack-pointer writes |
| rdata_o | output | 8 | Registered read data |
| bit_rdata_o | output | 1 | Registered bit read data |
| sp_o | output | 7 | Current stack pointer |

## Verification
The assertions assume a legal operation code, from 0 to 11, in every cycle after reset. They also assume that op_i is 0 while reset is held, because the one-cycle-later checks compare against the operation seen at the previous edge. The stimulus draws codes only from the legal set, drives them only after reset has been released through the synchronizer, and fills every byte before it makes any random read. This way no property meets an undefined memory word.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_RD_BYTE  = 4'd1,
    OP_WR_BYTE  = 4'd2,
    OP_RD_REG   = 4'd3,
    OP_WR_REG   = 4'd4,
    OP_RD_BIT   = 4'd5,
    OP_SET_BIT  = 4'd6,
    OP_CLR_BIT  = 4'd7,
    OP_PUSH     = 4'd8,
    OP_POP      = 4'd9,
    OP_WR_SP    = 4'd10,
    OP_SET_BANK = 4'd11
  } iram_op_e;

  function automatic logic is_byte_read(iram_op_e op);
    return (op == OP_RD_BYTE) || (op == OP_RD_REG) || (op == OP_POP);
  endfunction

  function automatic logic is_bit_op(iram_op_e op);
    return (op == OP_RD_BIT) || (op == OP_SET_BIT) || (op == OP_CLR_BIT);
  endfunction
endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int REG_W     = 3,
  parameter int BANK_W    = 2,
  parameter int BITADDR_W = 7,
  parameter int BITPOS_W  = 3,
  parameter logic [ADDR_W-1:0] BIT_BASE = 7'h20
) (
  input  iram_op_e              op_i,
  input  logic [ADDR_W-1:0]     byte_addr_i,
  input  logic [REG_W-1:0]      reg_num_i,
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [BITADDR_W-1:0]  bit_addr_i,
  input  logic [ADDR_W-1:0]     sp_i,
  output logic [ADDR_W-1:0]     acc_addr_o,
  output logic [BITPOS_W-1:0]   bit_pos_o
);
  localparam int BITBYTE_W = BITADDR_W - BITPOS_W;

  logic [ADDR_W-1:0] reg_addr;
  logic [ADDR_W-1:0] bit_byte_addr;

  assign reg_addr      = ADDR_W'({bank_i, reg_num_i});
  assign bit_byte_addr = BIT_BASE + ADDR_W'(bit_addr_i[BITADDR_W-1 -: BITBYTE_W]);
  assign bit_pos_o     = bit_addr_i[BITPOS_W-1:0];

  always_comb begin
    case (op_i)
      OP_RD_REG, OP_WR_REG:             acc_addr_o = reg_addr;
      OP_RD_BIT, OP_SET_BIT, OP_CLR_BIT: acc_addr_o = bit_byte_addr;
      OP_PUSH:                          acc_addr_o = sp_i + ADDR_W'(1);
      OP_POP:                           acc_addr_o = sp_i;
      default:                          acc_addr_o = byte_addr_i;
    endcase
  end
endmodule

// File: rtl/iram_storage.sv
module iram_storage #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  // R2: a written word reads back its data at the next edge
  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/iram_ctrl_regs.sv
module iram_ctrl_regs
  import iram_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter logic [ADDR_W-1:0] SP_RESET = 7'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  iram_op_e          op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              sp_en, bank_en;

  always_comb begin
    sp_en = 1'b1;
    case (op_i)
      OP_PUSH:  sp_d = sp_q + ADDR_W'(1);
      OP_POP:   sp_d = sp_q - ADDR_W'(1);
      OP_WR_SP: sp_d = wdata_i[ADDR_W-1:0];
      default: begin
        sp_d  = sp_q;
        sp_en = 1'b0;
      end
    endcase
    bank_en = (op_i == OP_SET_BANK);
    bank_d  = bank_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= SP_RESET;
      bank_q <= '0;
    end else begin
      if (sp_en)   sp_q   <= sp_d;
      if (bank_en) bank_q <= bank_d;
    end
  end

  assign sp_o   = sp_q;
  assign bank_o = bank_q;

  assert_push_incr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH) |=> (sp_q == $past(sp_q) + ADDR_W'(1)));
  assert_pop_decr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP) |=> (sp_q == $past(sp_q) - ADDR_W'(1)));
  assert_sp_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WR_SP) |=> (sp_q == $past(wdata_i[ADDR_W-1:0])));
  assert_sp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_i inside {OP_PUSH, OP_POP, OP_WR_SP}) |=> $stable(sp_q));
  assert_bank_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SET_BANK) |=> (bank_q == $past(bank_sel_i)));
endmodule

// File: rtl/iram_banked.sv
module iram_banked
  import iram_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int REG_W     = 3,
  parameter int BANK_W    = 2,
  parameter int BITADDR_W = 7,
  parameter logic [ADDR_W-1:0] BIT_BASE = 7'h20,
  parameter logic [ADDR_W-1:0] SP_RESET = 7'h07
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [3:0]           op_i,
  input  logic [ADDR_W-1:0]    byte_addr_i,
  input  logic [REG_W-1:0]     reg_num_i,
  input  logic [BANK_W-1:0]    bank_sel_i,
  input  logic [BITADDR_W-1:0] bit_addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 bit_rdata_o,
  output logic [ADDR_W-1:0]    sp_o
);
  localparam int BITPOS_W = $clog2(DATA_W);

  iram_op_e            op;
  logic [1:0]          rst_sync_q;
  logic                rst_n;
  logic [ADDR_W-1:0]   sp, acc_addr;
  logic [BANK_W-1:0]   bank;
  logic [BITPOS_W-1:0] bit_pos;
  logic [DATA_W-1:0]   mem_rd, bit_wdata, mem_wdata;
  logic                mem_we, set_val;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                bit_q, bit_d;
  logic                rdata_en, bit_en;

  assign op = iram_op_e'(op_i);

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  iram_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .SP_RESET(SP_RESET)
  ) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_n), .op_i(op), .wdata_i(wdata_i),
    .bank_sel_i(bank_sel_i), .sp_o(sp), .bank_o(bank)
  );

  iram_addr_map #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .BANK_W(BANK_W),
    .BITADDR_W(BITADDR_W), .BITPOS_W(BITPOS_W), .BIT_BASE(BIT_BASE)
  ) map_i (
    .op_i(op), .byte_addr_i(byte_addr_i), .reg_num_i(reg_num_i), .bank_i(bank),
    .bit_addr_i(bit_addr_i), .sp_i(sp), .acc_addr_o(acc_addr), .bit_pos_o(bit_pos)
  );

  // read-modify-write of one bit, other bits pass through
  assign set_val = (op == OP_SET_BIT);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit_merge
    assign bit_wdata[g] = (bit_pos == BITPOS_W'(g)) ? set_val : mem_rd[g];
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = wdata_i;
    case (op)
      OP_WR_BYTE, OP_WR_REG, OP_PUSH: mem_we = 1'b1;
      OP_SET_BIT, OP_CLR_BIT: begin
        mem_we    = 1'b1;
        mem_wdata = bit_wdata;
      end
      default: mem_we = 1'b0;
    endcase
  end

  iram_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(mem_we), .addr_i(acc_addr),
    .wdata_i(mem_wdata), .rdata_o(mem_rd)
  );

  always_comb begin
    rdata_en = is_byte_read(op);
    rdata_d  = mem_rd;
    bit_en   = (op == OP_RD_BIT);
    bit_d    = mem_rd[bit_pos];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      bit_q   <= 1'b0;
    end else begin
      if (rdata_en) rdata_q <= rdata_d;
      if (bit_en)   bit_q   <= bit_d;
    end
  end

  assign rdata_o     = rdata_q;
  assign bit_rdata_o = bit_q;
  assign sp_o        = sp;

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !is_byte_read(op) |=> $stable(rdata_q));
  assert_bit_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op != OP_RD_BIT) |=> $stable(bit_q));
  assert_bit_window_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    is_bit_op(op) |-> (acc_addr >= BIT_BASE && acc_addr < BIT_BASE + ADDR_W'(16)));
  assert_bit_other_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op == OP_SET_BIT || op == OP_CLR_BIT) |->
      ($countones(mem_wdata ^ mem_rd) <= 1));
  assert_legal_op_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    op_i <= 4'd11);
endmodule

// File: tb/iram_banked_tb.sv
`timescale 1ns/1ps
module iram_banked_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op;
  logic [6:0] byte_addr, bit_addr;
  logic [2:0] reg_num;
  logic [1:0] bank_sel;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       bit_rdata;
  logic [6:0] sp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] m [128];
  logic [6:0] e_sp;
  logic [1:0] e_bank;
  logic [7:0] e_rd;
  logic       e_bit;

  always #2.5 clk = ~clk;

  iram_banked dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .byte_addr_i(byte_addr),
    .reg_num_i(reg_num), .bank_sel_i(bank_sel), .bit_addr_i(bit_addr),
    .wdata_i(wdata), .rdata_o(rdata), .bit_rdata_o(bit_rdata), .sp_o(sp)
  );

  function automatic string req_of(logic [3:0] o);
    case (o)
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4, 4'd11: return "R3";
      4'd5: return "R6";
      4'd6, 4'd7: return "R5";
      4'd8: return "R7";
      4'd9: return "R8";
      4'd10: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [6:0] bit_byte(logic [6:0] b);
    return 7'h20 + {3'b000, b[6:3]};
  endfunction

  task automatic model(logic [3:0] o);
    logic [6:0] a;
    case (o)
      4'd1: e_rd = m[byte_addr];
      4'd2: m[byte_addr] = wdata;
      4'd3: e_rd = m[{e_bank, reg_num}];
      4'd4: m[{e_bank, reg_num}] = wdata;
      4'd5: e_bit = m[bit_byte(bit_addr)][bit_addr[2:0]];
      4'd6: begin a = bit_byte(bit_addr); m[a][bit_addr[2:0]] = 1'b1; end
      4'd7: begin a = bit_byte(bit_addr); m[a][bit_addr[2:0]] = 1'b0; end
      4'd8: begin e_sp = e_sp + 7'd1; m[e_sp] = wdata; end
      4'd9: begin e_rd = m[e_sp]; e_sp = e_sp - 7'd1; end
      4'd10: e_sp = wdata[6:0];
      4'd11: e_bank = bank_sel;
      default: ;
    endcase
  endtask

  task automatic check_outs(string req);
    checks++;
    if (rdata !== e_rd || bit_rdata !== e_bit || sp !== e_sp) begin
      failures++;
      $display("FAIL %s: rdata=%h bit=%b sp=%h expected rdata=%h bit=%b sp=%h",
               req, rdata, bit_rdata, sp, e_rd, e_bit, e_sp);
    end
  endtask

  task automatic run_op(logic [3:0] o, logic [6:0] ba, logic [2:0] rn, logic [1:0] bs,
                        logic [6:0] bi, logic [7:0] wd, string req);
    op = o; byte_addr = ba; reg_num = rn; bank_sel = bs; bit_addr = bi; wdata = wd;
    model(o);
    @(negedge clk);
    check_outs(req);
  endtask

  task automatic check_byte(logic [6:0] a, string req);
    run_op(4'd1, a, 3'd0, 2'd0, 7'd0, 8'd0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    op = 4'd0; byte_addr = '0; reg_num = '0; bank_sel = '0; bit_addr = '0; wdata = '0;
    rst_n = 1'b0;
    e_sp = 7'h07; e_bank = 2'd0; e_rd = 8'h00; e_bit = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_outs("R1");

    // fill memory, R2
    for (int a = 0; a < 128; a++) run_op(4'd2, 7'(a), 3'd0, 2'd0, 7'd0, 8'(a) ^ 8'h5A, "R2");
    check_byte(7'h00, "R2");
    check_byte(7'h7F, "R2");
    check_byte(7'h45, "R2");

    // default bank 0 after reset, R1 and R3
    run_op(4'd3, 7'd0, 3'd5, 2'd3, 7'd0, 8'd0, "R1");
    run_op(4'd11, 7'd0, 3'd0, 2'd2, 7'd0, 8'd0, "R3");
    run_op(4'd4, 7'd0, 3'd3, 2'd0, 7'd0, 8'hC3, "R3");
    check_byte(7'h13, "R3");
    run_op(4'd11, 7'd0, 3'd0, 2'd3, 7'd0, 8'd0, "R3");
    run_op(4'd3, 7'd0, 3'd7, 2'd0, 7'd0, 8'd0, "R3");

    // bit 67H is bit 7 of byte 2CH, R4 and R5
    run_op(4'd2, 7'h2C, 3'd0, 2'd0, 7'd0, 8'h00, "R5");
    run_op(4'd6, 7'd0, 3'd0, 2'd0, 7'h67, 8'd0, "R4");
    check_byte(7'h2C, "R4");
    run_op(4'd2, 7'h20, 3'd0, 2'd0, 7'd0, 8'hFF, "R5");
    run_op(4'd7, 7'd0, 3'd0, 2'd0, 7'h03, 8'd0, "R5");
    check_byte(7'h20, "R5");
    run_op(4'd5, 7'd0, 3'd0, 2'd0, 7'h03, 8'd0, "R6");
    run_op(4'd5, 7'd0, 3'd0, 2'd0, 7'h04, 8'd0, "R6");
    run_op(4'd5, 7'd0, 3'd0, 2'd0, 7'h7F, 8'd0, "R6");
    run_op(4'd0, 7'd0, 3'd0, 2'd0, 7'd0, 8'd0, "R10");

    // stack, R7 R8 R9
    run_op(4'd8, 7'd0, 3'd0, 2'd0, 7'd0, 8'hA1, "R7");
    check_byte(7'h08, "R7");
    run_op(4'd8, 7'd0, 3'd0, 2'd0, 7'd0, 8'hB2, "R7");
    run_op(4'd9, 7'd0, 3'd0, 2'd0, 7'd0, 8'd0, "R8");
    run_op(4'd9, 7'd0, 3'd0, 2'd0, 7'd0, 8'd0, "R8");
    run_op(4'd10, 7'd0, 3'd0, 2'd0, 7'd0, 8'hFF, "R9");
    run_op(4'd8, 7'd0, 3'd0, 2'd0, 7'd0, 8'h3C, "R9");
    check_byte(7'h00, "R9");
    run_op(4'd9, 7'd0, 3'd0, 2'd0, 7'd0, 8'd0, "R9");
    run_op(4'd9, 7'd0, 3'd0, 2'd0, 7'd0, 8'd0, "R9");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] o;
      o = 4'($urandom_range(0, 11));
      run_op(o, 7'($urandom_range(0, 127)), 3'($urandom_range(0, 7)),
             2'($urandom_range(0, 3)), 7'($urandom_range(0, 127)),
             8'($urandom_range(0, 255)), req_of(o));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule